// File: doc/BRIEF.md
# Dual Down-Counting Timer with Interrupt Registers

This peripheral holds two independent down-counting timers behind a simple 32-bit word register bus. Each timer has a reload (divider) register and a control register. The control register picks one of three operations (load, hold, run) and a clock-source code. The clock-source code chooses which tick-enable strobe drives the timer: one external strobe, or one of several internal-rate strobes. The block makes no clocks of its own; every strobe is a one-cycle enable in the `clk` domain.

When a running timer counts down to its end, it reloads from its divider and sets its own bit in a shared raw interrupt register. It does both in the same cycle and keeps counting. Software can do the following:
- mask the raw bits;
- read the raw bits, or the masked view of them;
- clear raw bits by writing ones to an acknowledge address, which keeps no value of its own.

A single level interrupt output is high while any unmasked raw bit is set. A free-running 32-bit time register also counts every clock cycle.

The bus is a plain register port with no stream handshake. A write is accepted in the cycle that `bus_we` is high. Reads are combinational from `bus_addr`. The bus never stalls, so there is no back-pressure to manage.

Top module: `dtr_dual_timer`

## Requirements
- R1: After reset, the following read zero: raw interrupt (0x50), mask (0x48), masked interrupt (0x54), both timer counts (0x04 and 0x14), and `irq_o`. Both control registers (0x08 and 0x18) read 0x1, which is hold with source code 0, so no timer counts until software changes its control.
- R2: With control bits [1:0] = 0 (load), the timer count is set to the timer's divider value on every clock edge. A new divider value therefore shows up in the count one cycle after it is written.
- R3: With control bits [1:0] = 1 (hold) or 3 (illegal, treated as hold), the count keeps its value whatever strobes arrive.
- R4: With control bits [1:0] = 2 (run), the count drops by exactly one on each cycle in which the selected tick strobe is high. It does not change in cycles where that strobe is low.
- R5: Control bits [4:2] select the tick strobe. Code 0 selects `ext_tick`. Codes 4, 5, 6 and 7 select `int_tick[0]`, `int_tick[1]`, `int_tick[2]` and `int_tick[3]`. Codes 1, 2 and 3 select nothing, so the timer never ticks.
- R6: A selected tick in run mode while the count is 0 or 1 is an expiry. In the same cycle the count reloads from the divider and the raw interrupt bit for that timer is set: bit 0 for timer0, bit 1 for timer1. With a divider of D ≥ 1 the timer expires every D ticks; with a divider of 0 it expires on every tick.
- R7: Writing to the acknowledge address 0x4C clears each raw bit whose written bit is 1 and leaves the others alone. Reads of 0x4C return 0.
- R8: If an expiry and an acknowledge of the same bit happen in the same cycle, the bit stays set.
- R9: The masked view (0x54) reads raw AND mask, and `irq_o` is high exactly when that value is nonzero. A mask write shows on `irq_o` right after the edge that takes the write. Mask and raw bits above bit 1 read zero.
- R10: The time register at 0x38 goes up by one on every clock cycle and wraps at 2^32.
- R11: The timer registers sit at these offsets:

  | Register | Timer0 | Timer1 |
  |---|---|---|
  | divider | 0x00 | 0x10 |
  | count | 0x04 | 0x14 |
  | control | 0x08 | 0x18 |

  Writes to read-only addresses (counts, time, raw, masked) have no effect. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 7 | Byte address of the word register |
| bus_we | input | 1 | Write strobe for `bus_wdata` at `bus_addr` |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| ext_tick | input | 1 | External tick strobe (source code 0) |
| int_tick | input | 4 | Internal-rate tick strobes (source codes 4 to 7) |
| irq_o | output | 1 | Level interrupt: any masked raw bit set |

## Verification
The bench sweeps all eight source codes against each of the five strobes. A mux decoded off by one would count on the wrong strobe, and a reserved code wrongly wired would count when it should not. It also sweeps dividers 0 to 4 through several periods. A design that reloads one tick late shows a period of D+1, and one that decrements below zero wraps the count to all ones. Two cases target the acknowledge logic: an acknowledge landing in the same cycle as an expiry, where a design that lets the acknowledge win loses the interrupt, and a partial acknowledge, where a design that clears the whole register drops a bit it should keep. Hold and the illegal code are checked under live strobes, and writes to read-only addresses are checked for no effect.

// File: rtl/dtr_pkg.sv
package dtr_pkg;

  // Register layout (byte addresses)
  localparam int TMR_STRIDE = 'h10;
  localparam int OFS_DIV    = 'h00;
  localparam int OFS_DATA   = 'h04;
  localparam int OFS_CTRL   = 'h08;
  localparam int ADR_TIME   = 'h38;
  localparam int ADR_MASK   = 'h48;
  localparam int ADR_ACK    = 'h4C;
  localparam int ADR_RAW    = 'h50;
  localparam int ADR_MASKED = 'h54;

  // Control field layout
  localparam int OP_W         = 2;
  localparam int SRC_W        = 3;
  localparam int CTRL_W       = OP_W + SRC_W;
  localparam int SRC_EXT      = 0;
  localparam int SRC_INT_BASE = 4;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_BAD  = 2'd3
  } tmr_op_e;

  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(OP_HOLD);

  function automatic int tmr_adr(input int idx, input int ofs);
    return idx * TMR_STRIDE + ofs;
  endfunction

endpackage

// File: rtl/dtr_tick_sel.sv
module dtr_tick_sel
  import dtr_pkg::*;
#(
  parameter int N_INT = 4
) (
  input  logic [SRC_W-1:0] src,
  input  logic             ext_tick,
  input  logic [N_INT-1:0] int_tick,
  output logic             tick
);

  logic [N_INT-1:0] hit;

  // One comparator per internal strobe; codes outside the decoded set never tick.
  for (genvar g = 0; g < N_INT; g++) begin : g_int
    assign hit[g] = int_tick[g] && (int'(src) == SRC_INT_BASE + g);
  end

  assign tick = ((int'(src) == SRC_EXT) && ext_tick) || (|hit);

endmodule

// File: rtl/dtr_down_counter.sv
module dtr_down_counter
  import dtr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_op_e          op,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             expire
);

  logic at_end;

  assign at_end = (count <= CNT_W'(1));
  assign expire = (op == OP_RUN) && tick && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      case (op)
        OP_LOAD: count <= reload;
        OP_RUN: begin
          if (tick) begin
            count <= at_end ? reload : count - CNT_W'(1);
          end
        end
        default: count <= count;  // hold and illegal code
      endcase
    end
  end

endmodule

// File: rtl/dtr_irq_unit.sv
module dtr_irq_unit #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wd,
  input  logic         ack_we,
  input  logic [N-1:0] ack_wd,
  output logic [N-1:0] raw,
  output logic [N-1:0] mask,
  output logic [N-1:0] masked,
  output logic         irq
);

  logic [N-1:0] ack_clr;

  assign ack_clr = ack_we ? ack_wd : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw  <= '0;
      mask <= '0;
    end else begin
      raw <= (raw & ~ack_clr) | hit;  // new expiry overrides a same-cycle clear
      if (mask_we) begin
        mask <= mask_wd;
      end
    end
  end

  assign masked = raw & mask;
  assign irq    = |masked;

endmodule

// File: rtl/dtr_dual_timer.sv
module dtr_dual_timer
  import dtr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 7,
  parameter int N_INT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_tick,
  input  logic [N_INT-1:0]  int_tick,
  output logic              irq_o
);

  localparam int NUM_TMR = 2;

  logic [CNT_W-1:0]   div_q  [NUM_TMR];
  logic [CTRL_W-1:0]  ctrl_q [NUM_TMR];
  logic [CNT_W-1:0]   cnt_q  [NUM_TMR];
  logic [NUM_TMR-1:0] tmr_tick;
  logic [NUM_TMR-1:0] tmr_exp;
  logic [NUM_TMR-1:0] irq_raw;
  logic [NUM_TMR-1:0] irq_mask;
  logic [NUM_TMR-1:0] irq_masked;
  logic [DATA_W-1:0]  time_q;
  logic               mask_we;
  logic               ack_we;

  assign mask_we = bus_we && (int'(bus_addr) == ADR_MASK);
  assign ack_we  = bus_we && (int'(bus_addr) == ADR_ACK);

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    logic div_we;
    logic ctrl_we;

    assign div_we  = bus_we && (int'(bus_addr) == tmr_adr(t, OFS_DIV));
    assign ctrl_we = bus_we && (int'(bus_addr) == tmr_adr(t, OFS_CTRL));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        div_q[t]  <= '0;
        ctrl_q[t] <= CTRL_RST;
      end else begin
        if (div_we)  div_q[t]  <= bus_wdata[CNT_W-1:0];
        if (ctrl_we) ctrl_q[t] <= bus_wdata[CTRL_W-1:0];
      end
    end

    dtr_tick_sel #(
      .N_INT(N_INT)
    ) u_sel (
      .src      (ctrl_q[t][CTRL_W-1:OP_W]),
      .ext_tick (ext_tick),
      .int_tick (int_tick),
      .tick     (tmr_tick[t])
    );

    dtr_down_counter #(
      .CNT_W(CNT_W)
    ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (tmr_op_e'(ctrl_q[t][OP_W-1:0])),
      .tick   (tmr_tick[t]),
      .reload (div_q[t]),
      .count  (cnt_q[t]),
      .expire (tmr_exp[t])
    );
  end

  dtr_irq_unit #(
    .N(NUM_TMR)
  ) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (tmr_exp),
    .mask_we (mask_we),
    .mask_wd (bus_wdata[NUM_TMR-1:0]),
    .ack_we  (ack_we),
    .ack_wd  (bus_wdata[NUM_TMR-1:0]),
    .raw     (irq_raw),
    .mask    (irq_mask),
    .masked  (irq_masked),
    .irq     (irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
    end else begin
      time_q <= time_q + DATA_W'(1);
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int t = 0; t < NUM_TMR; t++) begin
      if (int'(bus_addr) == tmr_adr(t, OFS_DIV))  bus_rdata = DATA_W'(div_q[t]);
      if (int'(bus_addr) == tmr_adr(t, OFS_DATA)) bus_rdata = DATA_W'(cnt_q[t]);
      if (int'(bus_addr) == tmr_adr(t, OFS_CTRL)) bus_rdata = DATA_W'(ctrl_q[t]);
    end
    if (int'(bus_addr) == ADR_TIME)   bus_rdata = time_q;
    if (int'(bus_addr) == ADR_MASK)   bus_rdata = DATA_W'(irq_mask);
    if (int'(bus_addr) == ADR_RAW)    bus_rdata = DATA_W'(irq_raw);
    if (int'(bus_addr) == ADR_MASKED) bus_rdata = DATA_W'(irq_masked);
  end

endmodule

// File: rtl/dtr_dual_timer_chk.sv
module dtr_dual_timer_chk
  import dtr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq_o,
  input logic [1:0]        raw,
  input logic [1:0]        mask,
  input logic [1:0]        exp,
  input logic              tick0,
  input logic [1:0]        op0,
  input logic [CNT_W-1:0]  cnt0,
  input logic [CNT_W-1:0]  div0,
  input logic [DATA_W-1:0] time_q
);

  logic ack_wr;
  assign ack_wr = bus_we && (int'(bus_addr) == ADR_ACK);

  AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (op0 == 2'd0) |=> (cnt0 == $past(div0)));  // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (op0 == 2'd1 || op0 == 2'd3) |=> (cnt0 == $past(cnt0)));  // R3

  AST_RUN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (op0 == 2'd2 && !tick0) |=> $stable(cnt0));  // R4

  AST_EXPIRY_SETS_T0: assert property (@(posedge clk) disable iff (!rst_n)
    exp[0] |=> raw[0]);  // R6

  AST_EXPIRY_SETS_T1: assert property (@(posedge clk) disable iff (!rst_n)
    exp[1] |=> raw[1]);  // R6

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && bus_wdata[0] && !exp[0]) |=> !raw[0]);  // R7

  AST_EXPIRY_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && bus_wdata[1] && exp[1]) |=> raw[1]);  // R8

  AST_NO_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 2'b00) |-> !irq_o);  // R9

  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (time_q == DATA_W'($past(time_q) + DATA_W'(1))));  // R10

endmodule

bind dtr_dual_timer dtr_dual_timer_chk #(
  .DATA_W(DATA_W),
  .CNT_W (CNT_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .irq_o    (irq_o),
  .raw      (irq_raw),
  .mask     (irq_mask),
  .exp      (tmr_exp),
  .tick0    (tmr_tick[0]),
  .op0      (ctrl_q[0][1:0]),
  .cnt0     (cnt_q[0]),
  .div0     (div_q[0]),
  .time_q   (time_q)
);

// File: tb/sim_dtr_dual_timer.sv
`timescale 1ns/1ps
module sim_dtr_dual_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ext_tick = 1'b0;
  logic [3:0]  int_tick = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dtr_dual_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_tick(ext_tick),
    .int_tick(int_tick), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 7'(a); bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 7'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic e, input logic [3:0] i);
    @(negedge clk);
    ext_tick = e; int_tick = i;
    @(posedge clk); #1;
    ext_tick = 1'b0; int_tick = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, t1;
    int m, expc;
    bit fired;

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd('h50, v); chk("R1 raw", v, 0);
    rd('h48, v); chk("R1 mask", v, 0);
    rd('h54, v); chk("R1 masked", v, 0);
    rd('h04, v); chk("R1 cnt0", v, 0);
    rd('h14, v); chk("R1 cnt1", v, 0);
    rd('h08, v); chk("R1 ctrl0", v, 1);
    rd('h18, v); chk("R1 ctrl1", v, 1);
    chk("R1 irq", {31'b0, irq_o}, 0);
    pulse(1'b1, 4'hF);
    rd('h04, v); chk("R1 cnt0 held", v, 0);

    // R10 time register
    rd('h38, t1); idle(10); rd('h38, v);
    chk("R10 time step", v, t1 + 32'd10);

    // R2 load
    wr('h00, 5); wr('h08, 0); idle(1);
    rd('h04, v); chk("R2 load", v, 5);
    wr('h00, 7); idle(1);
    rd('h04, v); chk("R2 load follows", v, 7);

    // R5/R4 source sweep: every code against every strobe
    for (int code = 0; code < 8; code++) begin
      wr('h00, 9); wr('h08, code << 2); idle(1);
      wr('h08, (code << 2) | 2);
      expc = 9;
      for (int s = 0; s < 5; s++) begin
        pulse(s == 0, (s > 0) ? 4'(1 << (s - 1)) : 4'h0);
        if ((s == 0 && code == 0) || (s > 0 && code == 3 + s)) expc--;
        rd('h04, v); chk($sformatf("R5 code%0d strobe%0d", code, s), v, 32'(expc));
      end
      idle(3);
      rd('h04, v); chk($sformatf("R4 idle code%0d", code), v, 32'(expc));
    end

    // R3 hold and illegal op
    wr('h00, 6); wr('h08, 0); idle(1); wr('h08, 2);
    pulse(1'b1, 4'h0);
    rd('h04, v); chk("R4 run step", v, 5);
    wr('h08, 1); pulse(1'b1, 4'hF);
    rd('h04, v); chk("R3 hold", v, 5);
    wr('h08, 3); pulse(1'b1, 4'hF);
    rd('h04, v); chk("R3 illegal op", v, 5);
    wr('h08, 2); pulse(1'b1, 4'h0);
    rd('h04, v); chk("R4 resume", v, 4);

    // R6 expiry sweep over dividers
    for (int d = 0; d < 5; d++) begin
      wr('h00, d); wr('h08, 0); idle(1); wr('h08, 2); wr('h4C, 3);
      m = d;
      for (int k = 0; k < 10; k++) begin
        pulse(1'b1, 4'h0);
        fired = (m <= 1);
        m = fired ? d : m - 1;
        rd('h04, v); chk($sformatf("R6 div%0d tick%0d count", d, k), v, 32'(m));
        rd('h50, v); chk($sformatf("R6 div%0d tick%0d raw", d, k), v, {31'b0, fired});
        chk("R9 irq masked off", {31'b0, irq_o}, 0);
        if (fired) wr('h4C, 1);
      end
    end

    // R9 mask and R7 acknowledge
    wr('h00, 1); wr('h08, 0); idle(1); wr('h08, 2); wr('h4C, 3);
    pulse(1'b1, 4'h0);
    rd('h50, v); chk("R6 raw set", v, 1);
    rd('h54, v); chk("R9 masked zero", v, 0);
    chk("R9 irq low", {31'b0, irq_o}, 0);
    wr('h48, 1);
    chk("R9 irq after mask", {31'b0, irq_o}, 1);
    rd('h54, v); chk("R9 masked", v, 1);
    wr('h4C, 2);
    rd('h50, v); chk("R7 partial ack keeps", v, 1);
    wr('h4C, 1);
    rd('h50, v); chk("R7 ack clears", v, 0);
    chk("R7 irq drops", {31'b0, irq_o}, 0);
    rd('h4C, v); chk("R7 ack reads zero", v, 0);

    // R8 expiry and acknowledge in the same cycle (count is 1, divider 1)
    @(negedge clk);
    bus_addr = 7'h4C; bus_wdata = 32'h1; bus_we = 1'b1; ext_tick = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0; ext_tick = 1'b0;
    rd('h50, v); chk("R8 expiry wins", v, 1);
    rd('h04, v); chk("R8 reload", v, 1);

    // Timer1 on code 6 (int_tick[2])
    wr('h08, 1); wr('h4C, 3); wr('h48, 0);
    wr('h10, 2); wr('h18, 6 << 2); idle(1); wr('h18, (6 << 2) | 2);
    pulse(1'b1, 4'h0);
    rd('h14, v); chk("R5 timer1 ignores ext", v, 2);
    pulse(1'b0, 4'h4);
    rd('h14, v); chk("R4 timer1 step", v, 1);
    pulse(1'b0, 4'h4);
    rd('h14, v); chk("R6 timer1 reload", v, 2);
    rd('h50, v); chk("R6 timer1 raw bit1", v, 2);
    wr('h48, 32'hFFFF_FFFF);
    rd('h48, v); chk("R9 mask upper bits", v, 3);
    rd('h54, v); chk("R9 masked t1", v, 2);
    chk("R9 irq t1", {31'b0, irq_o}, 1);

    // R11 map: unmapped reads and read-only writes
    rd('h20, v); chk("R11 unmapped", v, 0);
    rd('h0C, v); chk("R11 gap", v, 0);
    wr('h54, 32'hFFFF_FFFF);
    rd('h54, v); chk("R11 masked ro", v, 2);
    wr('h50, 0);
    rd('h50, v); chk("R11 raw ro", v, 2);
    wr('h14, 32'h55);
    rd('h14, v); chk("R11 count ro", v, 2);
    rd('h10, v); chk("R11 div1 readback", v, 2);

    // R1 reset in the middle of activity
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R1 irq after reset", {31'b0, irq_o}, 0);
    rd('h50, v); chk("R1 raw after reset", v, 0);
    rd('h48, v); chk("R1 mask after reset", v, 0);
    rd('h18, v); chk("R1 ctrl1 after reset", v, 1);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule